// File: doc/BRIEF.md
# Multiplexed Bidirectional Port Controller

This block manages one parallel general-purpose I/O port of `W` pins (eight by default). For every pin it decides which agent drives the pad, and it produces the pad's output-enable, output value and weak pull-up enable. There are three possible agents. An external multiplexed address/data bus has the highest rank. A parallel master port comes next. The port's own direction and output-latch registers have the lowest rank. The block also returns the pad levels after a two-flop synchronizer, both on a dedicated output and through the register read path.

Software reaches the block through a small register port of plain strobes. A write takes effect on the clock edge where `wr_en` is high. A read is combinational from `rd_addr`. The port accepts every access, so it exerts no back-pressure and has no handshake. The external bus and the parallel master port are not modelled here. They appear only as per-pin drive-enable and drive-value inputs, plus an activity flag for the parallel master port.

Register map, selected by the 2-bit address: 0 = PINS (a write loads the output latch, a read returns the synchronized pads), 1 = OUTLAT (the output latch, read/write), 2 = DIRN (direction, 1 = input), 3 = CTRL (bit 0 = global pull-up enable, bit 1 = external-bus disable, bit 2 = parallel-master-port select, other bits read 0).

Top module: `gpio_mux_port`

## Requirements
- R1: After any reset, DIRN reads all ones, OUTLAT reads 0, and CTRL reads 3'b010, meaning pull-ups off, external bus disabled and parallel master port deselected. As a result, `pad_oe` and `pad_pu` are all zero.
- R2: When CTRL bit 1 is 1 and the parallel master port does not own the pins, `pad_oe[i]` equals the inverse of DIRN bit i and `pad_out` equals OUTLAT.
- R3: A write to address 0 or to address 1 loads `wr_data` into the output latch, and a read of address 1 returns the latch contents.
- R4: `pin_rd` and a read of address 0 return `pad_in` as it was sampled two clock edges earlier.
- R5: When CTRL bit 1 is 0, `pad_oe` equals `ebus_oe` and `pad_out` equals `ebus_out`, whatever the values of DIRN, OUTLAT or the parallel-master-port inputs.
- R6: When CTRL bit 1 is 1, CTRL bit 2 is 1 and `pmp_active` is 1, `pad_oe` equals `pmp_oe` and `pad_out` equals `pmp_out`.
- R7: If either CTRL bit 2 or `pmp_active` is 0, the parallel-master-port inputs have no effect on the pads.
- R8: `pad_pu[i]` is 1 exactly when CTRL bit 0 is 1 and `pad_oe[i]` is 0.
- R9: DIRN and CTRL read back the values last written, with the CTRL fields at bits 0, 1 and 2.
- R10: A write to DIRN while the external bus owns the pins leaves the pads unchanged. The written value takes over once CTRL bit 1 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | W | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | W | Register read data (combinational) |
| pad_in | input | W | Pad levels (asynchronous) |
| pad_oe | output | W | Per-pin output enable |
| pad_out | output | W | Per-pin output value |
| pad_pu | output | W | Per-pin weak pull-up enable |
| pin_rd | output | W | Synchronized pad levels |
| ebus_oe | input | W | External bus drive enables |
| ebus_out | input | W | External bus drive values |
| pmp_active | input | 1 | Parallel master port is active |
| pmp_oe | input | W | Parallel master port drive enables |
| pmp_out | input | W | Parallel master port drive values |

## Verification
Several properties are checked by the assertions on every cycle. A driven pin never has its pull-up on. An enabled external bus always passes straight through to the pads. When the port owns the pins, `pad_oe` mirrors the inverted direction register. Latch writes land one edge later, `pin_rd` trails `pad_in` by exactly two edges, and reset silences every output enable. Some behaviours can only be shown by the bench's scenarios: the three-way ranking under competing drive requests, the cases where parallel-master-port inputs are ignored, register readback with its field positions, and a direction write that is hidden behind the bus and only appears once the bus is released.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_PINS = 2'd0,
    REG_LAT  = 2'd1,
    REG_DIR  = 2'd2,
    REG_CTRL = 2'd3
  } reg_sel_e;

  // CTRL field positions
  localparam int CTRL_PU_BIT  = 0;
  localparam int CTRL_EBD_BIT = 1;
  localparam int CTRL_PMP_BIT = 2;
  localparam int CTRL_FIELDS  = 3;

  typedef enum logic [1:0] {
    OWN_GPIO = 2'd0,
    OWN_PMP  = 2'd1,
    OWN_EBUS = 2'd2
  } owner_e;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_mux_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  output logic [W-1:0]      dir_q,
  output logic [W-1:0]      lat_q,
  output logic              pu_en,
  output logic              ext_dis,
  output logic              pmp_sel
);
  logic hit_lat, hit_dir, hit_ctrl;

  always_comb begin
    hit_lat  = wr_en && (wr_addr == REG_PINS || wr_addr == REG_LAT);
    hit_dir  = wr_en && (wr_addr == REG_DIR);
    hit_ctrl = wr_en && (wr_addr == REG_CTRL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '1;
      lat_q   <= '0;
      pu_en   <= 1'b0;
      ext_dis <= 1'b1;
      pmp_sel <= 1'b0;
    end else begin
      if (hit_lat) lat_q <= wr_data;
      if (hit_dir) dir_q <= wr_data;
      if (hit_ctrl) begin
        pu_en   <= wr_data[CTRL_PU_BIT];
        ext_dis <= wr_data[CTRL_EBD_BIT];
        pmp_sel <= wr_data[CTRL_PMP_BIT];
      end
    end
  end
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '0;
        else if (s == 0) chain[s] <= d;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_owner_mux.sv
module gpio_owner_mux
  import gpio_mux_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         ext_dis,
  input  logic         pmp_sel,
  input  logic         pmp_active,
  input  logic         pu_en,
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] lat_q,
  input  logic [W-1:0] ebus_oe,
  input  logic [W-1:0] ebus_out,
  input  logic [W-1:0] pmp_oe,
  input  logic [W-1:0] pmp_out,
  output owner_e       owner,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_pu
);
  // Fixed ranking: external bus, then parallel master port, then GPIO.
  always_comb begin
    if (!ext_dis)                    owner = OWN_EBUS;
    else if (pmp_sel && pmp_active)  owner = OWN_PMP;
    else                             owner = OWN_GPIO;
  end

  generate
    for (genvar i = 0; i < W; i++) begin : g_pin
      logic oe_i, out_i;
      always_comb begin
        unique case (owner)
          OWN_EBUS: begin oe_i = ebus_oe[i]; out_i = ebus_out[i]; end
          OWN_PMP:  begin oe_i = pmp_oe[i];  out_i = pmp_out[i];  end
          default:  begin oe_i = ~dir_q[i];  out_i = lat_q[i];    end
        endcase
      end
      assign pad_oe[i]  = oe_i;
      assign pad_out[i] = out_i;
      assign pad_pu[i]  = pu_en & ~oe_i;
    end
  endgenerate
endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port
  import gpio_mux_pkg::*;
#(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [W-1:0]      rd_data,
  input  logic [W-1:0]      pad_in,
  output logic [W-1:0]      pad_oe,
  output logic [W-1:0]      pad_out,
  output logic [W-1:0]      pad_pu,
  output logic [W-1:0]      pin_rd,
  input  logic [W-1:0]      ebus_oe,
  input  logic [W-1:0]      ebus_out,
  input  logic              pmp_active,
  input  logic [W-1:0]      pmp_oe,
  input  logic [W-1:0]      pmp_out
);
  localparam int CTRL_PAD = W - CTRL_FIELDS;

  logic [W-1:0] dir_q, lat_q;
  logic         pu_en, ext_dis, pmp_sel;
  owner_e       owner;

  gpio_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .dir_q(dir_q), .lat_q(lat_q), .pu_en(pu_en),
    .ext_dis(ext_dis), .pmp_sel(pmp_sel)
  );

  gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pin_rd)
  );

  gpio_owner_mux #(.W(W)) u_mux (
    .ext_dis(ext_dis), .pmp_sel(pmp_sel), .pmp_active(pmp_active),
    .pu_en(pu_en), .dir_q(dir_q), .lat_q(lat_q), .ebus_oe(ebus_oe),
    .ebus_out(ebus_out), .pmp_oe(pmp_oe), .pmp_out(pmp_out),
    .owner(owner), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
  );

  always_comb begin
    unique case (rd_addr)
      REG_PINS: rd_data = pin_rd;
      REG_LAT:  rd_data = lat_q;
      REG_DIR:  rd_data = dir_q;
      default:  rd_data = {{CTRL_PAD{1'b0}}, pmp_sel, ext_dis, pu_en};
    endcase
  end
endmodule

// File: rtl/gpio_mux_port_chk.sv
module gpio_mux_port_chk
  import gpio_mux_pkg::*;
#(
  parameter int W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [W-1:0]      wr_data,
  input logic [W-1:0]      pad_in,
  input logic [W-1:0]      pad_oe,
  input logic [W-1:0]      pad_out,
  input logic [W-1:0]      pad_pu,
  input logic [W-1:0]      pin_rd,
  input logic [W-1:0]      ebus_oe,
  input logic [W-1:0]      ebus_out,
  input logic              pmp_active,
  input logic [W-1:0]      dir_q,
  input logic [W-1:0]      lat_q,
  input logic              ext_dis,
  input logic              pmp_sel
);
  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (pad_oe == '0 && pad_pu == '0));

  // R8
  pu_off_when_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & pad_pu) == '0);

  // R5
  ebus_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_dis |-> (pad_oe == ebus_oe && pad_out == ebus_out));

  // R2
  gpio_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_dis && !(pmp_sel && pmp_active)) |-> (pad_oe == ~dir_q && pad_out == lat_q));

  // R3
  latch_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr == REG_PINS || wr_addr == REG_LAT)) |=> (lat_q == $past(wr_data)));

  // R4
  sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2) |-> (pin_rd == $past(pad_in, 2)));
endmodule

bind gpio_mux_port gpio_mux_port_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
  .pad_pu(pad_pu), .pin_rd(pin_rd), .ebus_oe(ebus_oe), .ebus_out(ebus_out),
  .pmp_active(pmp_active), .dir_q(dir_q), .lat_q(lat_q),
  .ext_dis(ext_dis), .pmp_sel(pmp_sel)
);

// File: tb/gpio_mux_port_bench.sv
module gpio_mux_port_bench;
  localparam int PERIOD = 10;
  localparam int W = 8;

  typedef struct packed {
    logic [2:0] ctrl;
    logic [7:0] dir;
    logic [7:0] lat;
    logic       pact;
    logic [7:0] poe;
    logic [7:0] pout;
    logic [7:0] eoe;
    logic [7:0] eout;
    logic [7:0] xoe;
    logic [7:0] xout;
    logic [7:0] xpu;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t [0:NV-1] VECS = '{
    '{3'b011, 8'hCF, 8'hA5, 1'b0, 8'hFF, 8'hFF, 8'hFF, 8'h00, 8'h30, 8'hA5, 8'hCF}, // R2 R8
    '{3'b010, 8'h0F, 8'h3C, 1'b0, 8'hFF, 8'hFF, 8'hFF, 8'h00, 8'hF0, 8'h3C, 8'h00}, // R2 R8
    '{3'b111, 8'hFF, 8'h00, 1'b1, 8'h0F, 8'h96, 8'h33, 8'hCC, 8'h0F, 8'h96, 8'hF0}, // R6
    '{3'b111, 8'h55, 8'h81, 1'b0, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hAA, 8'h81, 8'h55}, // R7
    '{3'b011, 8'hF0, 8'h5A, 1'b1, 8'hFF, 8'h00, 8'hFF, 8'hFF, 8'h0F, 8'h5A, 8'hF0}, // R7
    '{3'b101, 8'h00, 8'hFF, 1'b1, 8'hFF, 8'hFF, 8'hC3, 8'h24, 8'hC3, 8'h24, 8'h3C}, // R5
    '{3'b000, 8'h00, 8'h77, 1'b0, 8'hFF, 8'hFF, 8'h00, 8'h5A, 8'h00, 8'h5A, 8'h00}, // R5
    '{3'b001, 8'hFF, 8'h00, 1'b0, 8'h00, 8'h00, 8'hFF, 8'hE7, 8'hFF, 8'hE7, 8'h00}  // R5
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b1;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_addr = '0, rd_addr = '0;
  logic [W-1:0] wr_data = '0, pad_in = '0;
  logic [W-1:0] ebus_oe = '0, ebus_out = '0, pmp_oe = '0, pmp_out = '0;
  logic         pmp_active = 1'b0;
  logic [W-1:0] rd_data, pad_oe, pad_out, pad_pu, pin_rd;

  int checks = 0;
  int fails  = 0;

  always #(PERIOD/2) clk = ~clk;

  gpio_mux_port u_gpio_mux_port (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu),
    .pin_rd(pin_rd), .ebus_oe(ebus_oe), .ebus_out(ebus_out),
    .pmp_active(pmp_active), .pmp_oe(pmp_oe), .pmp_out(pmp_out)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [1:0] a, input logic [W-1:0] exp);
    rd_addr = a;
    #1;
    check(req, rd_data, exp);
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 pad_oe", pad_oe, 8'h00);
    check("R1 pad_pu", pad_pu, 8'h00);
    rd_chk("R1 DIRN", 2'd2, 8'hFF);
    rd_chk("R1 OUTLAT", 2'd1, 8'h00);
    rd_chk("R1 CTRL", 2'd3, 8'h02);

    // Vector table
    for (int k = 0; k < NV; k++) begin
      vec_t v;
      v = VECS[k];
      wr(2'd3, {5'b0, v.ctrl});
      wr(2'd2, v.dir);
      wr((k % 2 == 0) ? 2'd0 : 2'd1, v.lat); // R3: both latch addresses
      pmp_active = v.pact; pmp_oe = v.poe; pmp_out = v.pout;
      ebus_oe = v.eoe; ebus_out = v.eout;
      @(negedge clk);
      check($sformatf("R2/R5/R6/R7 oe vec%0d", k), pad_oe, v.xoe);
      check($sformatf("R2/R5/R6/R7 out vec%0d", k), pad_out, v.xout);
      check($sformatf("R8 pu vec%0d", k), pad_pu, v.xpu);
      rd_chk($sformatf("R3 OUTLAT vec%0d", k), 2'd1, v.lat);
      rd_chk($sformatf("R9 DIRN vec%0d", k), 2'd2, v.dir);
      rd_chk($sformatf("R9 CTRL vec%0d", k), 2'd3, {5'b0, v.ctrl});
    end

    // R4 two-edge synchronizer
    pmp_active = 1'b0;
    @(negedge clk);
    pad_in = 8'h00;
    repeat (3) @(negedge clk);
    pad_in = 8'hA5;
    @(negedge clk);
    check("R4 pin_rd after one edge", pin_rd, 8'h00);
    @(negedge clk);
    check("R4 pin_rd after two edges", pin_rd, 8'hA5);
    rd_chk("R4 PINS read", 2'd0, 8'hA5);

    // R10 direction write hidden behind external bus
    ebus_oe = 8'h00; ebus_out = 8'h00;
    wr(2'd3, 8'h00);
    wr(2'd2, 8'hFF);
    wr(2'd2, 8'h00);
    @(negedge clk);
    check("R10 pads unchanged by DIRN", pad_oe, 8'h00);
    wr(2'd3, 8'h02);
    @(negedge clk);
    check("R10 DIRN takes over", pad_oe, 8'hFF);

    // R3 clear outputs through PINS write
    wr(2'd1, 8'hFF);
    check("R3 latch set", pad_out, 8'hFF);
    wr(2'd0, 8'h00);
    check("R3 cleared via PINS", pad_out, 8'h00);

    // R1 reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 oe under reset", pad_oe, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    rd_chk("R1 CTRL after re-reset", 2'd3, 8'h02);
    rd_chk("R1 DIRN after re-reset", 2'd2, 8'hFF);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule